// File: doc/BRIEF.md
# Edge-Triggered Interrupt Request Cell

This block is the control cell for one interrupt source of a small microcontroller. An asynchronous pin first passes through a synchronizer. A small edge-tracking state machine then watches the synchronized level. A falling or a rising transition, chosen by a polarity bit, latches a sticky pending flag. An external both-edges select can make both transitions count.

Software sees one byte-wide register. It holds a three-bit priority level, the pending flag, the polarity bit and a reserved bit. Software can clear the pending flag but can never set it. The flag also clears when the processor accepts the interrupt through an acknowledge input. The cell presents a request together with its level to an external arbiter, and only while the level is nonzero.

The edge tracker has three states:
- `ST_INIT` waits for the synchronizer to fill after reset and records the first valid level without reporting an edge. Its exits are the transitions *warm-low* and *warm-high*.
- `ST_LOW` has one exit, the transition *rise*, taken when the sample reads 1.
- `ST_HIGH` has one exit, the transition *fall*, taken when the sample reads 0.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `irq_req` is 0 and `irq_level` is 0.
- R2: A register write stores bits 2:0 (level), bit 4 (polarity) and bit 5 (reserved), and they read back at the same positions. Bits 7:6 always read 0.
- R3: With polarity 0 and both-edges off, a falling transition on `pin_raw` sets the pending flag in read bit 3. The flag is visible on the third rising clock edge after the pin changes. A rising transition does not set it.
- R4: With polarity 1 and both-edges off, a rising transition sets the pending flag and a falling transition does not.
- R5: With `both_edges` = 1 and polarity 0, both a rising and a falling transition set the pending flag.
- R6: Writing 1 to bit 3 leaves the pending flag unchanged. Writing 0 to bit 3 clears it.
- R7: If a detected edge arrives in the same cycle as a write of 0 to bit 3 or an acknowledge, the flag ends up set.
- R8: `ack` = 1 for one cycle with no edge in that cycle clears the pending flag.
- R9: `irq_req` is 1 exactly when the pending flag is 1 and the level is nonzero. `irq_level` always equals the stored level.
- R10: A pin level present at reset, and a change of the polarity bit, never set the pending flag on their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| pin_raw | input | 1 | Asynchronous interrupt pin |
| both_edges | input | 1 | Both-edges select from a separate register |
| ack | input | 1 | Processor acceptance of this interrupt |
| irq_req | output | 1 | Request to the arbiter |
| irq_level | output | 3 | Priority level to the arbiter |

## Verification
The assertions take for granted that `both_edges` is raised only while the stored polarity bit is 0. A violation fires a configuration check rather than producing defined behaviour. The stimulus keeps to this by always writing polarity 0 before it raises `both_edges`. It sets a new polarity only after `both_edges` has been lowered. Each pin change is held for several cycles, well longer than the synchronizer depth, so no transition is lost in the two-flop path.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
    localparam int REG_W   = 8;
    localparam int LVL_W   = 3;
    localparam int LVL_LSB = 0;
    localparam int FLG_BIT = 3;
    localparam int POL_BIT = 4;
    localparam int RSV_BIT = 5;

    typedef enum logic [1:0] {
        ST_INIT,
        ST_LOW,
        ST_HIGH
    } edge_st_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/edge_track.sv
module edge_track
    import edge_irq_pkg::*;
#(
    parameter int WARM = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp,
    output logic rise,
    output logic fall
);
    localparam int CW = $clog2(WARM + 1);

    edge_st_t state, state_nx;
    logic [CW-1:0] warm_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_INIT;
            warm_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_INIT && warm_cnt != CW'(WARM))
                warm_cnt <= warm_cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INIT: if (warm_cnt == CW'(WARM)) state_nx = smp ? ST_HIGH : ST_LOW;
            ST_LOW:  if (smp)  state_nx = ST_HIGH;
            ST_HIGH: if (!smp) state_nx = ST_LOW;
            default: state_nx = ST_INIT;
        endcase
    end

    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state)
            ST_INIT: ;
            ST_LOW:  rise = smp;
            ST_HIGH: fall = !smp;
            default: ;
        endcase
    end

    // R3
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise, fall}));
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
    import edge_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             hit,
    input  logic             ack,
    output logic [LVL_W-1:0] level,
    output logic             flag,
    output logic             pol,
    output logic             rsv
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
            pol   <= 1'b0;
            rsv   <= 1'b0;
        end else if (wr_en) begin
            level <= wr_data[LVL_LSB +: LVL_W];
            pol   <= wr_data[POL_BIT];
            rsv   <= wr_data[RSV_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          flag <= 1'b0;
        else if (hit)                        flag <= 1'b1;
        else if (ack)                        flag <= 1'b0;
        else if (wr_en && !wr_data[FLG_BIT]) flag <= 1'b0;
    end

    // R2
    lvl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> level == $past(wr_data[LVL_LSB +: LVL_W]));
    // R6
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(hit));
    // R7
    hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    // R8
    ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit) |=> !flag);
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import edge_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             pin_raw,
    input  logic             both_edges,
    input  logic             ack,
    output logic             irq_req,
    output logic [LVL_W-1:0] irq_level
);
    logic             pin_s, rise, fall, hit;
    logic [LVL_W-1:0] level;
    logic             flag, pol, rsv;

    pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s)
    );

    edge_track #(.WARM(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .smp(pin_s), .rise(rise), .fall(fall)
    );

    assign hit = both_edges ? (rise | fall) : (pol ? rise : fall);

    irq_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .hit(hit), .ack(ack), .level(level), .flag(flag), .pol(pol), .rsv(rsv)
    );

    always_comb begin
        rd_data                        = '0;
        rd_data[LVL_LSB +: LVL_W]      = level;
        rd_data[FLG_BIT]               = flag;
        rd_data[POL_BIT]               = pol;
        rd_data[RSV_BIT]               = rsv;
    end

    assign irq_req   = flag && (level != '0);
    assign irq_level = level;

    // R5
    both_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        both_edges |-> !pol);
    // R10
    pol_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && !fall) |=> !$rose(flag));
endmodule

// File: tb/test_edge_irq_ctrl.sv
module test_edge_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       pin_raw = 1'b1;
    logic       both_edges = 1'b0;
    logic       ack = 1'b0;
    logic       irq_req;
    logic [2:0] irq_level;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    edge_irq_ctrl i_edge_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_raw(pin_raw), .both_edges(both_edges),
        .ack(ack), .irq_req(irq_req), .irq_level(irq_level)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        pin_raw = v;
        wait_n(4);
    endtask

    initial begin
        wait_n(3);
        // R1 reset state, pin held high through reset
        chk("R1 rd", rd_data, 8'h00);
        chk("R1 req", irq_req, 0);
        chk("R1 lvl", irq_level, 0);
        rst_n = 1'b1;
        wait_n(6);
        // R10 pin level at reset does not flag
        chk("R10 reset level", rd_data[3], 0);

        // R2 write/readback of every level, polarity and reserved pattern
        for (int v = 0; v < 64; v++) begin
            logic [7:0] d;
            d = 8'(v) | 8'hC0;
            d[3] = 1'b0;
            wr(d);
            chk("R2 readback", rd_data, int'(d & 8'h37));
        end
        wr(8'h00);

        // R10 polarity toggling without pin activity
        wr(8'h10); wr(8'h00); wr(8'h10); wr(8'h00);
        wait_n(2);
        chk("R10 pol toggle", rd_data[3], 0);

        // R3/R4/R5 sweep: both-edge mode x polarity x transition direction
        for (int b = 0; b < 2; b++) begin
            for (int p = 0; p < 2 - b; p++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    logic exp_set;
                    both_edges = 1'b0;
                    wr(8'h00);
                    set_pin(dir == 1 ? 1'b0 : 1'b1);
                    wr({3'b000, 1'(p), 4'h0});
                    both_edges = 1'(b);
                    wait_n(1);
                    chk("R10 setup quiet", rd_data[3], 0);
                    set_pin(1'(dir));
                    exp_set = (b == 1) || (p == dir);
                    if (b == 1)      chk("R5 both edges", rd_data[3], int'(exp_set));
                    else if (p == 1) chk("R4 rising pol", rd_data[3], int'(exp_set));
                    else             chk("R3 falling pol", rd_data[3], int'(exp_set));
                end
            end
        end
        both_edges = 1'b0;

        // R9 sweep of level with flag set; writing 1 to bit 3 keeps it (R6)
        wr(8'h00);
        set_pin(1'b1);
        set_pin(1'b0);
        chk("R3 flag for R9", rd_data[3], 1);
        for (int l = 0; l < 8; l++) begin
            wr(8'h08 | 8'(l));
            chk("R6 write1 keeps", rd_data[3], 1);
            chk("R9 req", irq_req, int'(l != 0));
            chk("R9 level", irq_level, l);
        end
        // R6 write 0 clears; write 1 cannot set
        wr(8'h07);
        chk("R6 write0 clears", rd_data[3], 0);
        chk("R9 req off", irq_req, 0);
        wr(8'h0F);
        chk("R6 write1 no set", rd_data[3], 0);

        // R8 acknowledge clears
        set_pin(1'b1);
        set_pin(1'b0);
        chk("R8 pre", rd_data[3], 1);
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        chk("R8 ack clears", rd_data[3], 0);

        // R7 edge coincides with write 0 and with ack
        for (int k = 0; k < 2; k++) begin
            set_pin(1'b1);
            wr(8'h0F);
            pin_raw = 1'b0;
            wait_n(2);
            if (k == 0) begin wr_en = 1'b1; wr_data = 8'h07; end
            else        ack = 1'b1;
            @(negedge clk);
            wr_en = 1'b0; ack = 1'b0;
            chk(k == 0 ? "R7 edge vs write0" : "R7 edge vs ack", rd_data[3], 1);
            wr(8'h07);
        end

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule